// File: doc/BRIEF.md
# Two-Wire Serialized JTAG Shift Master

This block drives one JTAG shift over a two-wire link made of a link clock and a single bidirectional data line. Every JTAG bit costs three link time slots: first the data line carries the TMS level, then the TDI level, and in the third slot the master releases the line so the target can return its TDO bit. A caller hands over a format code and a 32-bit word on a valid/ready request channel. The master shifts the word out MSB first, collects the returned bits into a result word and moves the target TAP through its update state. Finally it parks TDI at a saved TCLK level and delivers the result on a valid/ready response channel.

Back-pressure rules: `req_ready` is high only while no shift runs and no response is waiting. A request whose `req_valid` falls in a cycle with `req_ready` low is not taken. A response stays on `rsp_valid`/`rsp_data`, unchanged, until the cycle in which `rsp_ready` is high. The link clock low and high phases are each a run-time count of system clocks, captured when a request is accepted.

Top module: `tw_jtag_shifter`

## Requirements
- R1: `req_fmt` codes 0, 1, 2 and 3 select 8, 16, 20 and 32 bits. Any other code starts no link activity and `busy` stays low. In the cycle after acceptance it returns `rsp_valid` with `rsp_data` equal to zero.
- R2: Every slot holds `link_clk` low for `lo_cycles` system clocks and then high for `hi_cycles` system clocks. Both counts are captured at acceptance, and a count of zero is treated as one. The first slot begins in the cycle after acceptance.
- R3: In the TDI slot of each data bit, the line carries the request word MSB first, starting at bit N-1 for an N-bit format.
- R4: In the TMS slot of each data bit, the line is low for every bit except the last, where it is high.
- R5: `dat_oe` is low throughout every TDO slot and high otherwise. `dat_i` is sampled in the last low-phase cycle of each data bit's TDO slot. The first sampled bit lands in result bit N-1 and the last in bit 0, and result bits above N-1 are zero.
- R6: After the last data bit, one slot triple carries TMS high and TDI high, with the line released in its TDO slot. A second triple follows with TMS low and TDI equal to the saved TCLK level. The link then goes idle.
- R7: For the 20-bit format, result bits [19:16] take raw capture bits [3:0] and result bits [15:0] take raw bits [19:4].
- R8: A pulse on `tclk_wr` while `busy` is low stores `tclk_val` as the saved TCLK level; a pulse while `busy` is high is ignored. When idle, `link_clk` is high, `dat_oe` is high and `dat_o` equals the saved level, which is 0 after reset.
- R9: `req_ready` equals not `busy` and not `rsp_valid`. `busy` rises in the cycle after a valid-format acceptance and falls in the cycle after the last cycle of the final slot.
- R10: `rsp_valid` rises together with the fall of `busy` and holds with stable `rsp_data` until accepted by `rsp_ready`. It clears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lo_cycles | input | 8 | Link clock low-phase length in system clocks |
| hi_cycles | input | 8 | Link clock high-phase length in system clocks |
| tclk_wr | input | 1 | Store `tclk_val` as the saved TCLK level |
| tclk_val | input | 1 | TCLK level to save |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_fmt | input | 3 | Shift length code |
| req_data | input | 32 | Word to shift out, right-aligned |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_data | output | 32 | Captured TDO word |
| busy | output | 1 | Shift in progress |
| link_clk | output | 1 | Link clock |
| dat_o | output | 1 | Data line drive value |
| dat_oe | output | 1 | Data line drive enable |
| dat_i | input | 1 | Data line sampled value |

## Verification
On every cycle, the embedded assertions check several things. The line is released only during a shift, and the link is idle with `link_clk` high whenever `busy` is low. Each rise of the link clock inside a shift follows a sample strobe, and a shift ends only from its parking triple. Requests are refused while busy, and held responses stay unchanged. Only the bench's scenarios can show the slot-by-slot content of the link for each format and phase setting, and the MSB-first assembly and 20-bit rotation of a known responder pattern. The same holds for clamping of zero phase counts, zero results for bad codes, and the saved TCLK level surviving a write that arrives mid-shift.

// File: rtl/tw_jtag_pkg.sv
`timescale 1ns/1ps
package tw_jtag_pkg;
  localparam int LEN_W = 6;

  typedef enum logic [1:0] {STG_IDLE, STG_SHIFT, STG_UPDATE, STG_PARK} stage_e;
  typedef enum logic [1:0] {SLT_TMS, SLT_TDI, SLT_TDO} slot_e;

  function automatic logic [LEN_W-1:0] fmt_bits(input logic [2:0] code);
    case (code)
      3'd0:    return LEN_W'(8);
      3'd1:    return LEN_W'(16);
      3'd2:    return LEN_W'(20);
      3'd3:    return LEN_W'(32);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/tw_link_timer.sv
`timescale 1ns/1ps
module tw_link_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [CW-1:0] lo_cfg,
  input  logic [CW-1:0] hi_cfg,
  output logic          lclk,
  output logic          sample,
  output logic          slot_end
);
  logic [CW-1:0] lo_r, hi_r, cnt;
  logic          ph;
  logic [CW-1:0] lo_eff, hi_eff;

  assign lo_eff = (lo_cfg == '0) ? CW'(1) : lo_cfg;
  assign hi_eff = (hi_cfg == '0) ? CW'(1) : hi_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_r <= CW'(1);
      hi_r <= CW'(1);
      cnt  <= '0;
      ph   <= 1'b0;
    end else if (load) begin
      lo_r <= lo_eff;
      hi_r <= hi_eff;
      cnt  <= '0;
      ph   <= 1'b0;
    end else if (run) begin
      if (!ph) begin
        if (cnt == lo_r - CW'(1)) begin
          ph  <= 1'b1;
          cnt <= '0;
        end else cnt <= cnt + CW'(1);
      end else begin
        if (cnt == hi_r - CW'(1)) begin
          ph  <= 1'b0;
          cnt <= '0;
        end else cnt <= cnt + CW'(1);
      end
    end
  end

  assign sample   = run && !ph && (cnt == lo_r - CW'(1));
  assign slot_end = run &&  ph && (cnt == hi_r - CW'(1));
  assign lclk     = run ? ph : 1'b1;

  // R2
  rise_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $rose(lclk)) |-> $past(sample));
endmodule

// File: rtl/tw_jtag_seq.sv
`timescale 1ns/1ps
module tw_jtag_seq
  import tw_jtag_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] data,
  input  logic          park_lvl,
  input  logic          slot_end,
  output logic          busy,
  output logic          cap_slot,
  output logic          finish,
  output logic          drv_d,
  output logic          drv_oe
);
  stage_e        stage;
  slot_e         slot;
  logic [LW-1:0] rem;
  logic [DW-1:0] sh;
  logic [LW:0]   align;

  assign align = (LW+1)'(DW) - {1'b0, len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= STG_IDLE;
      slot  <= SLT_TMS;
      rem   <= '0;
      sh    <= '0;
    end else if (start) begin
      stage <= STG_SHIFT;
      slot  <= SLT_TMS;
      rem   <= len;
      sh    <= data << align;
    end else if (slot_end) begin
      case (slot)
        SLT_TMS: slot <= SLT_TDI;
        SLT_TDI: begin
          slot <= SLT_TDO;
          if (stage == STG_SHIFT) sh <= sh << 1;
        end
        default: begin
          slot <= SLT_TMS;
          case (stage)
            STG_SHIFT:  if (rem == LW'(1)) stage <= STG_UPDATE;
                        else rem <= rem - LW'(1);
            STG_UPDATE: stage <= STG_PARK;
            default:    stage <= STG_IDLE;
          endcase
        end
      endcase
    end
  end

  assign busy     = (stage != STG_IDLE);
  assign cap_slot = (stage == STG_SHIFT) && (slot == SLT_TDO);
  assign finish   = slot_end && (stage == STG_PARK) && (slot == SLT_TDO);

  always_comb begin
    drv_oe = 1'b1;
    drv_d  = park_lvl;
    if (busy) begin
      case (slot)
        SLT_TMS: drv_d = (stage == STG_SHIFT) ? (rem == LW'(1)) : (stage == STG_UPDATE);
        SLT_TDI: drv_d = (stage == STG_SHIFT) ? sh[DW-1] :
                         (stage == STG_UPDATE) ? 1'b1 : park_lvl;
        default: begin
          drv_oe = 1'b0;
          drv_d  = 1'b0;
        end
      endcase
    end
  end

  // R6
  end_from_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(stage) == STG_PARK));
endmodule

// File: rtl/tw_jtag_capture.sv
`timescale 1ns/1ps
module tw_jtag_capture
  import tw_jtag_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic          cap_en,
  input  logic          bit_in,
  output logic [DW-1:0] result
);
  logic [DW-1:0] raw;
  logic          rot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= '0;
      rot <= 1'b0;
    end else if (start) begin
      raw <= '0;
      rot <= (len == LW'(20));
    end else if (cap_en) begin
      raw <= {raw[DW-2:0], bit_in};
    end
  end

  always_comb begin
    result = raw;
    if (rot) begin
      result        = '0;
      result[19:0]  = {raw[3:0], raw[19:4]};
    end
  end
endmodule

// File: rtl/tw_jtag_shifter.sv
`timescale 1ns/1ps
module tw_jtag_shifter
  import tw_jtag_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8,
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] lo_cycles,
  input  logic [CW-1:0] hi_cycles,
  input  logic          tclk_wr,
  input  logic          tclk_val,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [FW-1:0] req_fmt,
  input  logic [DW-1:0] req_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic          link_clk,
  output logic          dat_o,
  output logic          dat_oe,
  input  logic          dat_i
);
  localparam int LW = LEN_W;

  logic [LW-1:0] req_len;
  logic          fmt_ok, accept, start;
  logic          saved_tclk;
  logic          sample, slot_end, cap_slot, finish;
  logic [DW-1:0] result;

  assign req_len   = fmt_bits(3'(req_fmt));
  assign fmt_ok    = (req_len != '0);
  assign req_ready = !busy && !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign start     = accept && fmt_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) saved_tclk <= 1'b0;
    else if (tclk_wr && !busy) saved_tclk <= tclk_val;
  end

  tw_link_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start), .run(busy),
    .lo_cfg(lo_cycles), .hi_cfg(hi_cycles),
    .lclk(link_clk), .sample(sample), .slot_end(slot_end)
  );

  tw_jtag_seq #(.DW(DW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .len(req_len), .data(req_data),
    .park_lvl(saved_tclk), .slot_end(slot_end), .busy(busy),
    .cap_slot(cap_slot), .finish(finish), .drv_d(dat_o), .drv_oe(dat_oe)
  );

  tw_jtag_capture #(.DW(DW), .LW(LW)) u_cap (
    .clk(clk), .rst_n(rst_n), .start(start), .len(req_len),
    .cap_en(cap_slot && sample), .bit_in(dat_i), .result(result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !fmt_ok) begin
      rsp_valid <= 1'b1;
      rsp_data  <= '0;
    end else if (finish) begin
      rsp_valid <= 1'b1;
      rsp_data  <= result;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R5
  release_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_oe |-> busy);
  // R8
  idle_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (link_clk && dat_oe));
  // R9
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R9
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R1
  bad_fmt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !fmt_ok) |=> (rsp_valid && rsp_data == '0 && !busy));
endmodule

// File: tb/tw_jtag_shifter_tb.sv
`timescale 1ns/1ps
module tw_jtag_shifter_tb_top;
  typedef struct { bit c; bit oe; bit d; int r; } ent_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  lo_cycles = 8'd1, hi_cycles = 8'd1;
  logic        tclk_wr = 1'b0, tclk_val = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b0;
  logic [2:0]  req_fmt = '0;
  logic [31:0] req_data = '0;
  logic        req_ready, rsp_valid, busy, link_clk, dat_o, dat_oe;
  logic [31:0] rsp_data;
  logic        dat_i = 1'b0;

  int   n_chk = 0, n_bad = 0;
  bit   mon_on = 1'b0;
  bit   saved_m = 1'b0;
  bit   oe_prev = 1'b1;
  int   tdo_idx = 0;
  logic [31:0] pat = '0;
  ent_t q[$];

  tw_jtag_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .lo_cycles(lo_cycles), .hi_cycles(hi_cycles),
    .tclk_wr(tclk_wr), .tclk_val(tclk_val), .req_valid(req_valid),
    .req_ready(req_ready), .req_fmt(req_fmt), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .link_clk(link_clk), .dat_o(dat_o), .dat_oe(dat_oe), .dat_i(dat_i)
  );

  always #10 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // target responder: drives pattern bit k in the k-th released slot
  always @(negedge clk) begin
    if (!busy) tdo_idx = 0;
    else if (oe_prev && !dat_oe) begin
      dat_i = (tdo_idx < 32) ? pat[tdo_idx] : 1'b0;
      tdo_idx++;
    end
    oe_prev = dat_oe;
  end

  // cycle-by-cycle link comparison against the reference queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (q.size() > 0) begin
        ent_t e;
        e = q.pop_front();
        chk(32'(link_clk), 32'(e.c), "R2 link_clk");
        chk(32'(dat_oe), 32'(e.oe), "R5 dat_oe");
        if (e.oe) chk(32'(dat_o), 32'(e.d), $sformatf("R%0d dat_o", e.r));
        chk(32'(busy), 32'd1, "R9 busy during shift");
        chk(32'(req_ready), 32'd0, "R9 req_ready during shift");
      end else begin
        chk(32'(link_clk), 32'd1, "R8 idle link_clk");
        chk(32'(dat_oe), 32'd1, "R8 idle dat_oe");
        chk(32'(dat_o), 32'(saved_m), "R8 idle dat_o");
        chk(32'(busy), 32'd0, "R9 idle busy");
      end
    end
  end

  function automatic int len_of(input logic [2:0] f);
    case (f) 3'd0: return 8; 3'd1: return 16; 3'd2: return 20; 3'd3: return 32; default: return 0; endcase
  endfunction

  task automatic push_slot(input bit oe, input bit d, input int r, input int lo, input int hi);
    for (int i = 0; i < lo; i++) q.push_back('{c:1'b0, oe:oe, d:d, r:r});
    for (int i = 0; i < hi; i++) q.push_back('{c:1'b1, oe:oe, d:d, r:r});
  endtask

  task automatic do_shift(input logic [2:0] f, input logic [31:0] d, input logic [31:0] p,
                          input int lo, input int hi, input int hold, input bit poke);
    int n, L, le, he;
    logic [31:0] raw, expv;
    n  = len_of(f);
    le = (lo == 0) ? 1 : lo;
    he = (hi == 0) ? 1 : hi;
    @(negedge clk); #1;
    chk(32'(req_ready), 32'd1, "R9 ready before request");
    lo_cycles = 8'(lo); hi_cycles = 8'(hi);
    req_fmt = f; req_data = d; pat = p; req_valid = 1'b1;
    for (int b = n - 1; b >= 0; b--) begin
      push_slot(1'b1, (b == 0), 4, le, he);      // R4 TMS slot
      push_slot(1'b1, d[b], 3, le, he);          // R3 TDI slot
      push_slot(1'b0, 1'b0, 5, le, he);          // R5 TDO slot
    end
    if (n > 0) begin
      push_slot(1'b1, 1'b1, 6, le, he);          // R6 update triple
      push_slot(1'b1, 1'b1, 6, le, he);
      push_slot(1'b0, 1'b0, 6, le, he);
      push_slot(1'b1, 1'b0, 6, le, he);          // R6 park triple
      push_slot(1'b1, saved_m, 6, le, he);
      push_slot(1'b0, 1'b0, 6, le, he);
    end
    L = q.size();
    raw = '0;
    for (int k = 0; k < n; k++) raw = (raw << 1) | 32'(p[k]);
    expv = (n == 20) ? {12'h0, raw[3:0], raw[19:4]} : raw;   // R7 rotation
    @(posedge clk); #1;
    req_valid = 1'b0;
    for (int i = 0; i < L; i++) begin
      @(posedge clk); #1;
      if (poke && i == 2) begin
        req_valid = 1'b1; req_data = ~d; req_fmt = 3'd0;
        tclk_wr = 1'b1; tclk_val = ~saved_m;                 // R8 ignored while busy
      end
      if (poke && i == 4) begin
        req_valid = 1'b0; tclk_wr = 1'b0;
      end
    end
    chk(32'(rsp_valid), 32'd1, (n == 0) ? "R1 bad code response" : "R10 rsp_valid at end");
    chk(rsp_data, expv, (n == 0) ? "R1 zero result" : ((n == 20) ? "R7 rotated result" : "R5 captured result"));
    chk(32'(req_ready), 32'd0, "R9 not ready with response pending");
    for (int i = 0; i < hold; i++) begin
      @(posedge clk); #1;
      chk(32'(rsp_valid), 32'd1, "R10 held valid");
      chk(rsp_data, expv, "R10 held data");
    end
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0;
    chk(32'(rsp_valid), 32'd0, "R10 cleared after handshake");
    chk(32'(req_ready), 32'd1, "R9 ready after handshake");
  endtask

  task automatic write_tclk(input bit v);
    bit ign;
    @(negedge clk); #1;
    ign = busy;
    tclk_wr = 1'b1; tclk_val = v;
    @(posedge clk); #1;
    tclk_wr = 1'b0;
    if (!ign) saved_m = v;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(32'(link_clk), 32'd1, "R8 reset link_clk");
    chk(32'(dat_oe), 32'd1, "R8 reset dat_oe");
    chk(32'(dat_o), 32'd0, "R8 reset dat_o");
    chk(32'(busy), 32'd0, "R9 reset busy");
    chk(32'(rsp_valid), 32'd0, "R10 reset rsp_valid");
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(32'(req_ready), 32'd1, "R9 reset ready");
    mon_on = 1'b1;
    do_shift(3'd0, 32'h0000_00A5, 32'h0000_0036, 1, 1, 0, 1'b0);  // R1 8 bits
    do_shift(3'd1, 32'h0000_C3E1, 32'h0000_9B2D, 2, 1, 2, 1'b0);  // 16 bits
    do_shift(3'd2, 32'h000A_5F3C, 32'h000C_1E47, 1, 2, 3, 1'b0);  // R7 20 bits
    write_tclk(1'b1);                                              // R8 idle write
    do_shift(3'd3, 32'h8123_4567, 32'hF0E1_D2C3, 0, 0, 1, 1'b1);  // R2 zero clamp, R8 poke
    do_shift(3'd2, 32'hFFFF_FFFF, 32'h0008_0001, 3, 2, 0, 1'b0);  // R3 upper bits ignored
    do_shift(3'd5, 32'h1234_5678, 32'hFFFF_FFFF, 1, 1, 2, 1'b0);  // R1 bad code
    do_shift(3'd7, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1, 1, 0, 1'b0);  // R1 bad code
    write_tclk(1'b0);
    do_shift(3'd0, 32'h0000_0001, 32'hFFFF_FFFF, 2, 3, 0, 1'b0);
    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule